// File: doc/BRIEF.md
# Operate-Instruction Execution Unit

This unit carries out the data-manipulating instructions of a small 16-bit processor. Each cycle it may receive one instruction word together with a valid strobe. It splits the word into an opcode and register-index fields and reads one or two source operands from an internal bank of eight 16-bit general-purpose registers. It then forms a sum, a bitwise AND or a bitwise complement. The result goes back to the named destination register at the next rising clock edge.

Every register write also reclassifies the written value as negative, zero or positive. A three-flag condition register records this class, with exactly one flag set, and its outputs feed a branch unit directly. The flags come from the sign bit and the zero test of the 2's-complement result. Carry and overflow play no part. For example, a sum that wraps past 0x7FFF reads as negative.

The result of the instruction currently presented also appears combinationally on a result bus. This bus carries a valid bit, the destination index and the value about to be written. Fetch, memory access and control flow live in other blocks.

Top module: `opu_exec`

## Requirements
- R1: Synchronous active-high reset clears all eight registers to 0x0000 and sets the flags to zero-only (Z=1, N=0, P=0).
- R2: Opcode 0001 in bits [15:12] with bit 5 = 0 adds the register indexed by bits [8:6] to the register indexed by bits [2:0], modulo 2^16. It writes the sum to the register indexed by bits [11:9]. Bits [4:3] are expected to be 00.
- R3: In opcode 0001 or 0101 with bit 5 = 1, the second operand is bits [4:0] sign-extended to 16 bits, replacing the second register.
- R4: Opcode 0101 writes the bitwise AND of its two operands, with operand selection as in R2 and R3.
- R5: Opcode 1001 writes the bitwise complement of the register indexed by bits [8:6]. Bits [5:0] have no effect on the result.
- R6: After each register write, exactly one flag is set: N when bit 15 of the written value is 1, Z when the value is 0x0000, P otherwise. The flag update happens on the same edge as the write.
- R7: When the valid strobe is low, or the opcode is not 0001, 0101 or 1001, no register and no flag changes.
- R8: `res_valid` is high in exactly the cycles in which an instruction of R2 to R5 is presented with the strobe high. During those cycles `res_dst` and `res_data` show the destination index and the value that the next edge writes.
- R9: Source registers are read before the write of the same instruction lands, so an instruction whose destination is also a source uses the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| res_valid | output | 1 | An operate instruction executes this cycle |
| res_dst | output | 3 | Destination register index of that instruction |
| res_data | output | 16 | Value written at the next edge |
| flag_n | output | 1 | Last written value was negative |
| flag_z | output | 1 | Last written value was zero |
| flag_p | output | 1 | Last written value was positive |

## Verification
The bench sweeps every combination of destination, source and second-source index for all three operations, and every immediate value for every source register. This exposes swapped fields, a wrong sign extension of the 5-bit immediate, and a complement that reads the wrong source.

It forces the sum 0x7FFF + 1 and the sum 0x8000 + 0x8000. A flag derived from carry or overflow would then show positive instead of negative, or miss the zero.

Instructions whose destination is also a source catch a register bank that forwards the new value. Non-operate opcodes and a deasserted strobe are followed by a full readout of the registers, which catches any stray write. A mid-run reset checks that both the registers and the flags return to their starting state.

// File: rtl/opu_pkg.sv
`timescale 1ns/1ps
package opu_pkg;
    localparam int XLEN    = 16;
    localparam int NREG    = 8;
    localparam int RIDX    = $clog2(NREG);
    localparam int IMMW    = 5;
    localparam int OPW     = 4;

    // instruction field positions
    localparam int OP_LSB   = XLEN - OPW;
    localparam int DST_LSB  = OP_LSB - RIDX;
    localparam int SR1_LSB  = DST_LSB - RIDX;
    localparam int MODE_BIT = IMMW;
    localparam int SR2_LSB  = 0;

    localparam logic [OPW-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPW-1:0] OPC_AND = 4'b0101;
    localparam logic [OPW-1:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_AND = 2'd1,
        FN_NOT = 2'd2
    } alu_fn_e;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } cc_t;

    localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

    typedef struct packed {
        logic             act;
        alu_fn_e          fn;
        logic [RIDX-1:0]  dst;
        logic [RIDX-1:0]  src1;
        logic [RIDX-1:0]  src2;
        logic             use_imm;
        logic [XLEN-1:0]  imm;
    } uop_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] f);
        return {{(XLEN-IMMW){f[IMMW-1]}}, f};
    endfunction

    function automatic cc_t cc_classify(input logic [XLEN-1:0] v);
        cc_t c;
        c.n = v[XLEN-1];
        c.z = (v == '0);
        c.p = !v[XLEN-1] && (v != '0);
        return c;
    endfunction
endpackage

// File: rtl/opu_decode.sv
`timescale 1ns/1ps
module opu_decode
    import opu_pkg::*;
(
    input  logic            valid,
    input  logic [XLEN-1:0] instr,
    output uop_t            uop
);
    always_comb begin
        uop.dst     = instr[DST_LSB +: RIDX];
        uop.src1    = instr[SR1_LSB +: RIDX];
        uop.src2    = instr[SR2_LSB +: RIDX];
        uop.use_imm = instr[MODE_BIT];
        uop.imm     = sext_imm(instr[IMMW-1:0]);
        uop.fn      = FN_ADD;
        uop.act     = 1'b0;
        case (instr[OP_LSB +: OPW])
            OPC_ADD: begin
                uop.fn  = FN_ADD;
                uop.act = valid;
            end
            OPC_AND: begin
                uop.fn  = FN_AND;
                uop.act = valid;
            end
            OPC_NOT: begin
                uop.fn      = FN_NOT;
                uop.act     = valid;
                uop.use_imm = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/opu_regfile.sv
`timescale 1ns/1ps
module opu_regfile #(
    parameter int W = 16,
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [$clog2(N)-1:0] rd_a_idx,
    input  logic [$clog2(N)-1:0] rd_b_idx,
    output logic [W-1:0]         rd_a,
    output logic [W-1:0]         rd_b,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic [W-1:0]         wr_data
);
    localparam int IW = $clog2(N);

    logic [W-1:0] bank [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we && wr_idx == IW'(i))
                q <= wr_data;
        end
        assign bank[i] = q;
    end

    assign rd_a = bank[rd_a_idx];
    assign rd_b = bank[rd_b_idx];
endmodule

// File: rtl/opu_alu.sv
`timescale 1ns/1ps
module opu_alu
    import opu_pkg::*;
(
    input  alu_fn_e         fn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    always_comb begin
        case (fn)
            FN_ADD:  y = a + b;
            FN_AND:  y = a & b;
            FN_NOT:  y = ~a;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/opu_ccreg.sv
`timescale 1ns/1ps
module opu_ccreg
    import opu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [XLEN-1:0] value,
    output cc_t             cc
);
    always_ff @(posedge clk) begin
        if (rst)
            cc <= CC_RESET;
        else if (we)
            cc <= cc_classify(value);
    end
endmodule

// File: rtl/opu_exec.sv
`timescale 1ns/1ps
module opu_exec
    import opu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr,
    output logic            res_valid,
    output logic [RIDX-1:0] res_dst,
    output logic [XLEN-1:0] res_data,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_p
);
    uop_t            uop;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb_reg;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] alu_y;
    cc_t             cc;

    opu_decode u_dec (
        .valid (instr_valid),
        .instr (instr),
        .uop   (uop)
    );

    opu_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (uop.src1),
        .rd_b_idx (uop.src2),
        .rd_a     (opa),
        .rd_b     (opb_reg),
        .we       (uop.act),
        .wr_idx   (uop.dst),
        .wr_data  (alu_y)
    );

    assign opb = uop.use_imm ? uop.imm : opb_reg;

    opu_alu u_alu (
        .fn (uop.fn),
        .a  (opa),
        .b  (opb),
        .y  (alu_y)
    );

    opu_ccreg u_cc (
        .clk   (clk),
        .rst   (rst),
        .we    (uop.act),
        .value (alu_y),
        .cc    (cc)
    );

    assign res_valid = uop.act;
    assign res_dst   = uop.dst;
    assign res_data  = alu_y;
    assign flag_n    = cc.n;
    assign flag_z    = cc.z;
    assign flag_p    = cc.p;
endmodule

// File: rtl/opu_exec_chk.sv
`timescale 1ns/1ps
module opu_exec_chk
    import opu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            instr_valid,
    input logic [OPW-1:0]  op,
    input logic            res_valid,
    input logic [XLEN-1:0] res_data,
    input logic            flag_n,
    input logic            flag_z,
    input logic            flag_p
);
    // R1
    reset_flags_chk: assert property (@(posedge clk)
        rst |=> (flag_z && !flag_n && !flag_p));

    // R6
    flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({flag_n, flag_z, flag_p}) == 1);

    // R6
    flags_track_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> (flag_n == $past(res_data[XLEN-1]))
                   && (flag_z == ($past(res_data) == '0))
                   && (flag_p == (!$past(res_data[XLEN-1]) && $past(res_data) != '0)));

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> $stable({flag_n, flag_z, flag_p}));

    // R8
    res_gate_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid == (instr_valid && (op == OPC_ADD || op == OPC_AND || op == OPC_NOT)));
endmodule

bind opu_exec opu_exec_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .op          (instr[15:12]),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_p      (flag_p)
);

// File: tb/opu_exec_test.sv
`timescale 1ns/1ps
module opu_exec_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic        res_valid;
    logic [2:0]  res_dst;
    logic [15:0] res_data;
    logic        flag_n, flag_z, flag_p;

    localparam logic [3:0] ADD = 4'b0001;
    localparam logic [3:0] AND = 4'b0101;
    localparam logic [3:0] NOT = 4'b1001;

    opu_exec uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .res_valid(res_valid), .res_dst(res_dst), .res_data(res_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] mregs [8];
    logic mn, mz, mp;

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(logic [3:0] op, int d, int s1, logic m, logic [4:0] low);
        return {op, d[2:0], s1[2:0], m, low};
    endfunction

    function automatic bit is_operate(logic [3:0] op);
        return op == ADD || op == AND || op == NOT;
    endfunction

    task automatic step(logic v, logic [15:0] ins, string tag);
        logic [15:0] a, b, y;
        logic act;
        @(negedge clk);
        instr_valid = v;
        instr = ins;
        #1;
        a = mregs[ins[8:6]];
        b = ins[5] ? {{11{ins[4]}}, ins[4:0]} : mregs[ins[2:0]];
        act = v && is_operate(ins[15:12]);
        case (ins[15:12])
            ADD:     y = a + b;
            AND:     y = a & b;
            default: y = ~a;
        endcase
        check(tag, "res_valid", {15'b0, res_valid}, {15'b0, act});
        if (act) begin
            check(tag, "res_dst", {13'b0, res_dst}, {13'b0, ins[11:9]});
            check(tag, "res_data", res_data, y);
        end
        @(posedge clk);
        #1;
        instr_valid = 1'b0;
        if (act) begin
            mregs[ins[11:9]] = y;
            mn = y[15];
            mz = (y == 16'h0000);
            mp = !y[15] && (y != 16'h0000);
        end
        // R6: one-hot flags from the written value
        check(tag, "flags", {13'b0, flag_n, flag_z, flag_p}, {13'b0, mn, mz, mp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        instr_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
        for (int k = 0; k < 8; k++) mregs[k] = 16'h0000;
        mn = 1'b0; mz = 1'b1; mp = 1'b0;
        // R1: flags after reset
        check("R1", "reset flags", {13'b0, flag_n, flag_z, flag_p}, 16'h0002);
    endtask

    task automatic read_all(string tag);
        for (int k = 0; k < 8; k++)
            step(1'b1, enc(ADD, k, k, 1'b1, 5'd0), tag);
    endtask

    // R3: values built from immediates and doubling
    task automatic load_reg(int k, logic [15:0] v);
        step(1'b1, enc(AND, k, k, 1'b1, 5'd0), "R3");
        for (int bi = 15; bi >= 0; bi--) begin
            step(1'b1, enc(ADD, k, k, 1'b0, 5'(k)), "R2");
            if (v[bi]) step(1'b1, enc(ADD, k, k, 1'b1, 5'd1), "R3");
        end
    endtask

    task automatic reload();
        for (int k = 0; k < 8; k++) load_reg(k, 16'($urandom));
    endtask

    task automatic reg_sweep(logic [3:0] op, string tag);
        for (int d = 0; d < 8; d++)
            for (int s1 = 0; s1 < 8; s1++)
                for (int s2 = 0; s2 < 8; s2++) begin
                    logic [4:0] low;
                    logic m;
                    low = {2'b00, 3'(s2)};
                    m = 1'b0;
                    if (op == NOT) begin
                        low = 5'($urandom);
                        m = 1'($urandom);
                    end
                    step(1'b1, enc(op, d, s1, m, low), tag);
                end
    endtask

    initial begin
        mn = 1'b0; mz = 1'b1; mp = 1'b0;
        for (int k = 0; k < 8; k++) mregs[k] = 16'h0000;
        do_reset();
        read_all("R1");

        // R9: destination is also both sources
        load_reg(2, 16'h1234);
        step(1'b1, enc(ADD, 2, 2, 1'b0, 5'd2), "R9");
        read_all("R9");

        // R2/R6: wrap to negative and to zero
        load_reg(7, 16'h7FFF);
        step(1'b1, enc(ADD, 6, 7, 1'b1, 5'd1), "R6");
        check("R6", "wrap sum", mregs[6], 16'h8000);
        step(1'b1, enc(ADD, 5, 6, 1'b0, 5'd6), "R6");
        check("R6", "wrap to zero", mregs[5], 16'h0000);

        reload();
        reg_sweep(AND, "R4");
        reload();
        for (int opi = 0; opi < 2; opi++)
            for (int s1 = 0; s1 < 8; s1++)
                for (int imm = 0; imm < 32; imm++)
                    step(1'b1, enc(opi == 0 ? ADD : AND, (s1 + imm) % 8, s1, 1'b1, 5'(imm)), "R3");
        reload();
        reg_sweep(NOT, "R5");
        reload();
        reg_sweep(ADD, "R2");

        // R7: ignored instructions
        reload();
        for (int op = 0; op < 16; op++)
            if (!is_operate(4'(op))) begin
                step(1'b1, {4'(op), 12'($urandom)}, "R7");
                step(1'b1, {4'(op), 12'($urandom)}, "R7");
            end
        step(1'b0, enc(ADD, 0, 1, 1'b1, 5'd7), "R7");
        step(1'b0, enc(NOT, 3, 3, 1'b0, 5'd0), "R7");
        read_all("R7");

        // R8: result bus idles with strobe low
        step(1'b0, enc(AND, 4, 4, 1'b0, 5'd4), "R8");

        // R1: mid-run reset
        do_reset();
        read_all("R1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL all watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule